// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a 14-bit virtual address into a physical address with a small set of per-segment base/bounds pairs. The two most significant address bits pick a segment, and the remaining twelve bits are the offset inside it. Each mapped segment carries a growth direction. An upward segment adds the offset to its base. A downward segment counts back from its bounds, so the top offset lands on the bounds address. Any access that would land outside the segment's inclusive base-to-bounds window produces a fault in place of an address.

Supervisor code programs the pairs and direction bits through a write port that works only while the privileged-mode input is high. A write made without privilege is discarded and reported on a one-cycle flag. Translation requests are accepted on every cycle. The answer comes back one clock later, from a register, as a physical address and a fault bit.

Top module: `seg_xlate_unit`

## Requirements
- R1: Virtual address bits [13:12] select the segment and bits [11:0] form the offset. Segments 0, 1 and 2 are mapped.
- R2: In an upward segment the physical address is base + offset. The access succeeds when this value is no greater than bounds.
- R3: In a downward segment the physical address is bounds − (0xFFF − offset). Offset 0xFFF therefore maps to the bounds address itself.
- R4: The response faults if the computed address is above bounds, is below base, or overflows or underflows the 16-bit physical range.
- R5: Any request to segment 3 faults, whatever has been written to the configuration.
- R6: When rsp_fault is 1, rsp_paddr is 0.
- R7: A request with req_valid high at a clock edge gives rsp_valid high after that edge, with its result. Without a request, rsp_valid is low after the edge.
- R8: cfg_we with cfg_priv high updates one field of segment cfg_seg. The encoding of cfg_field is 0 for base, 1 for bounds and 2 for direction, where cfg_data bit 0 set to 1 means downward. Field code 3 has no effect, and neither does any write to segment 3.
- R9: cfg_we with cfg_priv low changes nothing and sets cfg_denied high for exactly the following cycle.
- R10: Reset clears every base and bounds to 0 and sets every direction to upward. rsp_valid, rsp_fault, rsp_paddr and cfg_denied all read 0.
- R11: A write that shares a clock edge with a request does not affect that request. It applies to requests from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privileged-mode qualifier for writes |
| cfg_seg | input | 2 | Segment to write |
| cfg_field | input | 2 | Field code: 0 base, 1 bounds, 2 direction, 3 none |
| cfg_data | input | 16 | Write data |
| cfg_denied | output | 1 | Unprivileged write was dropped |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 14 | Virtual address |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Access outside its segment, or segment unmapped |

## Verification
The bench probes the edges of each window: the last legal offset and the one just past it, in both directions. A design with an off-by-one in either comparison would pass one of these or fault the other. It places a base near the top of the address space and a bounds near zero, so a design that drops the carry or borrow would wrap to a small legal-looking address instead of faulting. It also flips a segment's direction, issues a write in the same cycle as a request, attempts unprivileged writes and writes with field code 3, and accesses segment 3. A design that anchored on the wrong register, bypassed the old value, let the write through or mapped segment 3 would return a wrong address or a missing fault.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      FLD_BASE  = 2'd0,
      FLD_BOUND = 2'd1,
      FLD_DIR   = 2'd2,
      FLD_NONE  = 2'd3
   } cfg_field_e;

   typedef enum logic {
      GROW_UP   = 1'b0,
      GROW_DOWN = 1'b1
   } grow_dir_e;
endpackage

// File: rtl/seg_cfg_bank.sv
module seg_cfg_bank
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W    = 2,
   parameter int PA_W     = 16,
   parameter int N_MAPPED = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [SEG_W-1:0]                   wr_seg,
   input  logic [1:0]                         wr_fld,
   input  logic [PA_W-1:0]                    wr_data,
   output logic [N_MAPPED-1:0][PA_W-1:0]      base_o,
   output logic [N_MAPPED-1:0][PA_W-1:0]      bound_o,
   output logic [N_MAPPED-1:0]                down_o
);
   generate
      for (genvar g = 0; g < N_MAPPED; g++) begin : g_seg
         localparam logic [SEG_W-1:0] SEG_ID = SEG_W'(g);
         logic hit;
         assign hit = wr_en && (wr_seg == SEG_ID);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_o[g]  <= '0;
               bound_o[g] <= '0;
               down_o[g]  <= GROW_UP;
            end else if (hit) begin
               case (cfg_field_e'(wr_fld))
                  FLD_BASE:  base_o[g]  <= wr_data;
                  FLD_BOUND: bound_o[g] <= wr_data;
                  FLD_DIR:   down_o[g]  <= wr_data[0];
                  default:   ;
               endcase
            end
         end
      end
   endgenerate
endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc #(
   parameter int SEG_W    = 2,
   parameter int OFF_W    = 12,
   parameter int PA_W     = 16,
   parameter int N_MAPPED = 3
) (
   input  logic [SEG_W-1:0]              seg,
   input  logic [OFF_W-1:0]              off,
   input  logic [N_MAPPED-1:0][PA_W-1:0] base_i,
   input  logic [N_MAPPED-1:0][PA_W-1:0] bound_i,
   input  logic [N_MAPPED-1:0]           down_i,
   output logic [PA_W-1:0]               paddr,
   output logic                          fault
);
   localparam logic [PA_W:0] MAX_OFF = {{(PA_W+1-OFF_W){1'b0}}, {OFF_W{1'b1}}};

   logic                 hit;
   logic [PA_W-1:0]      base_s, bound_s;
   logic                 down_s;
   logic [PA_W:0]        off_x, up_sum, dn_dist, dn_diff;
   logic                 up_bad, dn_bad;

   always_comb begin
      hit     = 1'b0;
      base_s  = '0;
      bound_s = '0;
      down_s  = 1'b0;
      for (int i = 0; i < N_MAPPED; i++) begin
         if (seg == SEG_W'(i)) begin
            hit     = 1'b1;
            base_s  = base_i[i];
            bound_s = bound_i[i];
            down_s  = down_i[i];
         end
      end
   end

   assign off_x   = {{(PA_W+1-OFF_W){1'b0}}, off};
   assign up_sum  = {1'b0, base_s} + off_x;
   assign dn_dist = MAX_OFF - off_x;
   assign dn_diff = {1'b0, bound_s} - dn_dist;

   assign up_bad = up_sum[PA_W] || (up_sum[PA_W-1:0] > bound_s);
   assign dn_bad = dn_diff[PA_W] || (dn_diff[PA_W-1:0] < base_s)
                   || (dn_diff[PA_W-1:0] > bound_s);

   always_comb begin
      if (!hit) begin
         fault = 1'b1;
         paddr = '0;
      end else if (down_s) begin
         fault = dn_bad;
         paddr = dn_bad ? '0 : dn_diff[PA_W-1:0];
      end else begin
         fault = up_bad;
         paddr = up_bad ? '0 : up_sum[PA_W-1:0];
      end
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
   parameter int VA_W     = 14,
   parameter int SEG_W    = 2,
   parameter int PA_W     = 16,
   parameter int N_MAPPED = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_priv,
   input  logic [SEG_W-1:0]  cfg_seg,
   input  logic [1:0]        cfg_field,
   input  logic [PA_W-1:0]   cfg_data,
   output logic              cfg_denied,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault
);
   localparam int OFF_W = VA_W - SEG_W;
   localparam int N_SEG = 1 << SEG_W;

   generate
      if (OFF_W < 1 || OFF_W > PA_W)
         $error("offset width must be between 1 and the physical width");
      if (N_MAPPED < 1 || N_MAPPED > N_SEG)
         $error("mapped segment count exceeds the segment space");
   endgenerate

   logic [N_MAPPED-1:0][PA_W-1:0] base_w, bound_w;
   logic [N_MAPPED-1:0]           down_w;
   logic [PA_W-1:0]               paddr_w;
   logic                          fault_w;
   logic                          wr_ok;

   assign wr_ok = cfg_we && cfg_priv;

   seg_cfg_bank #(.SEG_W(SEG_W), .PA_W(PA_W), .N_MAPPED(N_MAPPED)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_seg  (cfg_seg),
      .wr_fld  (cfg_field),
      .wr_data (cfg_data),
      .base_o  (base_w),
      .bound_o (bound_w),
      .down_o  (down_w)
   );

   seg_xlate_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .N_MAPPED(N_MAPPED)) i_calc (
      .seg     (req_vaddr[VA_W-1:OFF_W]),
      .off     (req_vaddr[OFF_W-1:0]),
      .base_i  (base_w),
      .bound_i (bound_w),
      .down_i  (down_w),
      .paddr   (paddr_w),
      .fault   (fault_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_paddr  <= '0;
         rsp_fault  <= 1'b0;
         cfg_denied <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         cfg_denied <= cfg_we && !cfg_priv;
         if (req_valid) begin
            rsp_paddr <= paddr_w;
            rsp_fault <= fault_w;
         end else begin
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int VA_W  = 14,
   parameter int SEG_W = 2,
   parameter int PA_W  = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic            cfg_priv,
   input logic            cfg_denied,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_fault
);
   localparam logic [SEG_W-1:0] SEG_HOLE = '1;

   p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0));

   p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_hole_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_vaddr[VA_W-1:VA_W-SEG_W] == SEG_HOLE) |=> rsp_fault);

   p_deny_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv) |=> cfg_denied);

   p_deny_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && !cfg_priv) |=> !cfg_denied);
endmodule

bind seg_xlate_unit seg_xlate_chk #(.VA_W(VA_W), .SEG_W(SEG_W), .PA_W(PA_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_priv   (cfg_priv),
   .cfg_denied (cfg_denied),
   .req_valid  (req_valid),
   .req_vaddr  (req_vaddr),
   .rsp_valid  (rsp_valid),
   .rsp_paddr  (rsp_paddr),
   .rsp_fault  (rsp_fault)
);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_priv = 1'b0;
   logic [1:0]  cfg_seg = '0, cfg_field = '0;
   logic [15:0] cfg_data = '0;
   logic        cfg_denied;
   logic        req_valid = 1'b0;
   logic [13:0] req_vaddr = '0;
   logic        rsp_valid, rsp_fault;
   logic [15:0] rsp_paddr;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   seg_xlate_unit i_seg_xlate_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_seg(cfg_seg),
      .cfg_field(cfg_field), .cfg_data(cfg_data), .cfg_denied(cfg_denied),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
   );

   // stimulus table after the base setup: virtual, expected physical, expected fault
   localparam int NV = 13;
   localparam logic [13:0] T_VA [NV] = '{14'h0010, 14'h03FF, 14'h0400, 14'h1010, 14'h1100,
      14'h13FF, 14'h1400, 14'h2FFF, 14'h2FFE, 14'h2C00, 14'h2BFF, 14'h3000, 14'h3ABC};
   localparam logic [15:0] T_PA [NV] = '{16'h0010, 16'h03FF, 16'h0000, 16'h0410, 16'h0500,
      16'h07FF, 16'h0000, 16'h13FF, 16'h13FE, 16'h1000, 16'h0000, 16'h0000, 16'h0000};
   localparam logic        T_FT [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
      1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam string       T_RQ [NV] = '{"R2", "R2", "R4", "R1", "R2",
      "R2", "R4", "R3", "R3", "R3", "R4", "R5", "R5"};

   task automatic check(string rq, logic [31:0] act, logic [31:0] exp, string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic wr(logic priv, logic [1:0] seg, logic [1:0] fld, logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_priv = priv; cfg_seg = seg; cfg_field = fld; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_priv = 1'b0;
   endtask

   task automatic xl(string rq, logic [13:0] va, logic [15:0] pa, logic ft);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      check(rq, {31'b0, rsp_valid}, 32'd1, "valid");
      check(rq, {31'b0, rsp_fault}, {31'b0, ft}, "fault");
      check("R6", {16'b0, rsp_paddr}, {16'b0, pa}, "paddr");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset values
      check("R10", {31'b0, rsp_valid}, 0, "valid");
      check("R10", {31'b0, rsp_fault}, 0, "fault");
      check("R10", {16'b0, rsp_paddr}, 0, "paddr");
      check("R10", {31'b0, cfg_denied}, 0, "denied");
      rst_n = 1'b1;
      xl("R10", 14'h0000, 16'h0000, 1'b0);
      xl("R10", 14'h0001, 16'h0000, 1'b1);
      @(negedge clk);
      check("R7", {31'b0, rsp_valid}, 0, "idle valid");

      // R8 privileged setup
      wr(1, 2'd0, 2'd0, 16'h0000); wr(1, 2'd0, 2'd1, 16'h03FF);
      wr(1, 2'd1, 2'd0, 16'h0400); wr(1, 2'd1, 2'd1, 16'h07FF);
      wr(1, 2'd2, 2'd0, 16'h1000); wr(1, 2'd2, 2'd1, 16'h13FF);
      wr(1, 2'd2, 2'd2, 16'h0001);
      for (int i = 0; i < NV; i++) xl(T_RQ[i], T_VA[i], T_PA[i], T_FT[i]);

      // R5 writes to segment 3 leave it unmapped
      wr(1, 2'd3, 2'd0, 16'h0000); wr(1, 2'd3, 2'd1, 16'hFFFF);
      xl("R5", 14'h3005, 16'h0000, 1'b1);

      // R9 unprivileged write dropped and flagged
      @(negedge clk);
      cfg_we = 1'b1; cfg_priv = 1'b0; cfg_seg = 2'd0; cfg_field = 2'd0; cfg_data = 16'h0200;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R9", {31'b0, cfg_denied}, 1, "denied set");
      @(negedge clk);
      check("R9", {31'b0, cfg_denied}, 0, "denied one cycle");
      xl("R9", 14'h0010, 16'h0010, 1'b0);

      // R8 field code 3 has no effect
      wr(1, 2'd0, 2'd3, 16'h0200);
      check("R8", {31'b0, cfg_denied}, 0, "no deny on priv");
      xl("R8", 14'h0010, 16'h0010, 1'b0);

      // R11 write and request in the same cycle
      @(negedge clk);
      cfg_we = 1'b1; cfg_priv = 1'b1; cfg_seg = 2'd1; cfg_field = 2'd0; cfg_data = 16'h0600;
      req_valid = 1'b1; req_vaddr = 14'h1010;
      @(negedge clk);
      cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
      check("R11", {16'b0, rsp_paddr}, 32'h0410, "old base used");
      xl("R11", 14'h1010, 16'h0610, 1'b0);

      // R8 direction flip on segment 1: top offset lands on bounds
      wr(1, 2'd1, 2'd2, 16'h0001);
      xl("R8", 14'h1FFF, 16'h07FF, 1'b0);
      xl("R3", 14'h1E00, 16'h0600, 1'b0);
      xl("R4", 14'h1DFF, 16'h0000, 1'b1);

      // R4 carry out of the physical range
      wr(1, 2'd0, 2'd0, 16'hFF00); wr(1, 2'd0, 2'd1, 16'hFFFF);
      xl("R4", 14'h00FF, 16'hFFFF, 1'b0);
      xl("R4", 14'h0100, 16'h0000, 1'b1);

      // R4 borrow below zero in a downward segment
      wr(1, 2'd2, 2'd0, 16'h0000); wr(1, 2'd2, 2'd1, 16'h0010);
      xl("R3", 14'h2FF0, 16'h0001, 1'b0);
      xl("R4", 14'h2000, 16'h0000, 1'b1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule